// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block passes eight-bit data between two bus ports, A and B, in either direction, without inversion. Each direction owns a storage register. The A-to-B register takes A-port data, and the B-to-A register takes B-port data. Each register is loaded by its own capture strobe on a high-to-low transition of that strobe. An active-low output enable and a direction input choose which port, if any, the block drives. For each direction, a source select decides whether the driven port carries the live data from the opposite port or the stored contents of that direction's register. This lets the block latch a bus value and replay it later. Capture still works while both outputs are switched off.

Each bidirectional port is modelled as three signals: a sampled input, a data output and an output enable. The capture strobes are sampled by the system clock. A capture happens on the clock edge at which a strobe is seen low after it was seen high on the previous edge. The output path is combinational from the port inputs, the control inputs and the registers.

Top module: `bus_xcvr_reg`

## Requirements
- R1: After a synchronous active-low reset, both storage registers hold zero. Replaying a register before any capture therefore drives 0x00.
- R2: While `oe_n` is 1, `a_oe` and `b_oe` are both 0, and `a_out` and `b_out` are both 0x00, whatever the data and select inputs are.
- R3: While `oe_n` is 0 and `dir` is 1, `b_oe` is 1 and `a_oe` is 0.
- R4: While `oe_n` is 0 and `dir` is 0, `a_oe` is 1 and `b_oe` is 0.
- R5: When B is driven and `sel_ab` is 0, `b_out` equals `a_in` in the same cycle, bit for bit and not inverted.
- R6: When B is driven and `sel_ab` is 1, `b_out` equals the A-to-B register.
- R7: When A is driven, `a_out` equals `b_in` if `sel_ba` is 0, and equals the B-to-A register if `sel_ba` is 1.
- R8: The A-to-B register loads `a_in` on a clock edge where `stb_ab` is sampled 0 and was sampled 1 on the previous edge. The new value is visible right after that edge.
- R9: The B-to-A register loads `b_in` under the same high-to-low rule applied to `stb_ba`.
- R10: A strobe held high, or held low, does not load its register. Capture works while `oe_n` is 1.
- R11: Loading one direction's register leaves the other direction's register unchanged.
- R12: `a_oe` and `b_oe` are never both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| oe_n | input | 1 | Output enable, active low |
| dir | input | 1 | 1 drives B from the A side; 0 drives A from the B side |
| sel_ab | input | 1 | B source: 0 is live A data, 1 is the A-to-B register |
| sel_ba | input | 1 | A source: 0 is live B data, 1 is the B-to-A register |
| stb_ab | input | 1 | Capture strobe for the A-to-B register (falling transition) |
| stb_ba | input | 1 | Capture strobe for the B-to-A register (falling transition) |
| a_in | input | 8 | Data sampled from the A port |
| a_out | output | 8 | Data driven onto the A port |
| a_oe | output | 1 | A port driver enable |
| b_in | input | 8 | Data sampled from the B port |
| b_out | output | 8 | Data driven onto the B port |
| b_oe | output | 1 | B port driver enable |

## Verification
The live path is driven with complementary and alternating bit patterns, which expose any inverted or swapped bit. The stored path is replayed after captures made with the outputs off. Its value is chosen to differ from the live input at the moment of replay, so a wrong source select is visible. Strobes are held high and held low while the data changes, which separates true falling-edge capture from level capture. A capture on one side is followed by a replay of the other side, and a capture on both sides at once is also applied; together these show whether the two registers are cross-coupled.

// File: rtl/xcvr_pkg.sv
// Shared constants for the registered bus transceiver.
// Assumes two transfer directions, indexed as below everywhere.
package xcvr_pkg;
    localparam int unsigned NDIR   = 2;
    localparam int unsigned DIR_AB = 0;  // A port feeds B port
    localparam int unsigned DIR_BA = 1;  // B port feeds A port
endpackage

// File: rtl/strobe_fall_det.sv
// Detects a high-to-low transition of a capture strobe sampled by clk.
// Assumes the strobe is already synchronous to clk. After reset the history
// reads low, so a strobe must be seen high before a fall can be reported.
module strobe_fall_det (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic fall
);
    logic strobe_q;

    // Keep the strobe value from the previous clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= strobe;
    end

    assign fall = strobe_q & ~strobe;

    assert_fall_shape_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fall |-> ($past(strobe) && !strobe));
endmodule

// File: rtl/capture_reg.sv
// One direction's storage register: loads din when load is high, else holds.
// Assumes load is a single-cycle pulse from a strobe edge detector.
module capture_reg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    // Clear on reset, otherwise take din on a load pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= din;
    end

    assert_load_takes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (q == $past(din)));
    assert_hold_no_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q));
endmodule

// File: rtl/port_drive.sv
// Output side of one port: picks live or stored data and gates it by enable.
// Assumes enable is already decoded from the output enable and direction.
module port_drive #(
    parameter int unsigned W = 8
) (
    input  logic         enable,
    input  logic         use_stored,
    input  logic [W-1:0] live,
    input  logic [W-1:0] stored,
    output logic [W-1:0] dout,
    output logic         drive
);
    logic [W-1:0] chosen;

    // Pick the source, then force zero on an undriven port.
    always_comb begin
        chosen = use_stored ? stored : live;
        dout   = enable ? chosen : '0;
        drive  = enable;
    end
endmodule

// File: rtl/bus_xcvr_reg.sv
// Registered bidirectional transceiver between an A port and a B port.
// Each direction has a falling-strobe capture register and a live/stored
// select. oe_n (active low) and dir choose the single driven port.
// Assumes all inputs are synchronous to clk.
module bus_xcvr_reg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         oe_n,
    input  logic         dir,
    input  logic         sel_ab,
    input  logic         sel_ba,
    input  logic         stb_ab,
    input  logic         stb_ba,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic         b_oe
);
    import xcvr_pkg::*;

    logic [NDIR-1:0]        strobe_v;
    logic [NDIR-1:0]        fall_v;
    logic [NDIR-1:0]        en_v;
    logic [NDIR-1:0]        sel_v;
    logic [NDIR-1:0]        drv_v;
    logic [NDIR-1:0][W-1:0] src_v;
    logic [NDIR-1:0][W-1:0] store_v;
    logic [NDIR-1:0][W-1:0] out_v;

    // Gather per-direction inputs and decode which direction may drive.
    always_comb begin
        strobe_v[DIR_AB] = stb_ab;
        strobe_v[DIR_BA] = stb_ba;
        src_v[DIR_AB]    = a_in;
        src_v[DIR_BA]    = b_in;
        sel_v[DIR_AB]    = sel_ab;
        sel_v[DIR_BA]    = sel_ba;
        en_v[DIR_AB]     = ~oe_n &  dir;
        en_v[DIR_BA]     = ~oe_n & ~dir;
    end

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        strobe_fall_det i_fall (
            .clk    (clk),
            .rst_n  (rst_n),
            .strobe (strobe_v[d]),
            .fall   (fall_v[d])
        );

        capture_reg #(.W(W)) i_store (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (fall_v[d]),
            .din   (src_v[d]),
            .q     (store_v[d])
        );

        port_drive #(.W(W)) i_drive (
            .enable     (en_v[d]),
            .use_stored (sel_v[d]),
            .live       (src_v[d]),
            .stored     (store_v[d]),
            .dout       (out_v[d]),
            .drive      (drv_v[d])
        );
    end

    // A-to-B path drives the B port; B-to-A path drives the A port.
    always_comb begin
        b_out = out_v[DIR_AB];
        b_oe  = drv_v[DIR_AB];
        a_out = out_v[DIR_BA];
        a_oe  = drv_v[DIR_BA];
    end

    assert_one_driver_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_oe && b_oe));
    assert_quiet_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (!a_oe && !b_oe && a_out == '0 && b_out == '0));
    assert_live_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (b_oe && !sel_ab) |-> (b_out == a_in));
    assert_other_side_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_v[DIR_AB] && !fall_v[DIR_BA]) |=> $stable(store_v[DIR_BA]));
endmodule

// File: tb/test_bus_xcvr_reg.sv
module test_bus_xcvr_reg;
    typedef struct {
        logic [7:0] a_out;
        logic       a_oe;
        logic [7:0] b_out;
        logic       b_oe;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       oe_n = 1'b1, dir = 1'b0, sel_ab = 1'b0, sel_ba = 1'b0;
    logic       stb_ab = 1'b0, stb_ba = 1'b0;
    logic [7:0] a_in = '0, b_in = '0;
    logic [7:0] a_out, b_out;
    logic       a_oe, b_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    exp_t sb_q[$];

    // bench model state
    logic [7:0] m_ab = '0, m_ba = '0;
    logic       m_pab = 1'b0, m_pba = 1'b0;

    always #2 clk = ~clk;

    bus_xcvr_reg #(.W(8)) i_bus_xcvr_reg (
        .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .dir(dir),
        .sel_ab(sel_ab), .sel_ba(sel_ba), .stb_ab(stb_ab), .stb_ba(stb_ba),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
    );

    // Driver: apply inputs at a falling clock edge and queue the expectation.
    task automatic step(input logic [7:0] ai, input logic [7:0] bi,
                        input logic sab_s, input logic sba_s,
                        input logic oen, input logic dr,
                        input logic sa, input logic sb, input string tag);
        exp_t e;
        @(negedge clk);
        a_in = ai; b_in = bi; stb_ab = sab_s; stb_ba = sba_s;
        oe_n = oen; dir = dr; sel_ab = sa; sel_ba = sb;
        if (m_pab && !sab_s) m_ab = ai;
        if (m_pba && !sba_s) m_ba = bi;
        m_pab = sab_s;
        m_pba = sba_s;
        e.b_oe  = !oen && dr;
        e.a_oe  = !oen && !dr;
        e.b_out = e.b_oe ? (sa ? m_ab : ai) : 8'h00;
        e.a_out = e.a_oe ? (sb ? m_ba : bi) : 8'h00;
        e.tag   = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: one ns after each rising edge, compare against the queue head.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                checks++;
                if (a_out !== e.a_out || a_oe !== e.a_oe ||
                    b_out !== e.b_out || b_oe !== e.b_oe) begin
                    errors++;
                    $display("FAIL %s: got a_out=%h a_oe=%b b_out=%h b_oe=%b, expected a_out=%h a_oe=%b b_out=%h b_oe=%b",
                             e.tag, a_out, a_oe, b_out, b_oe,
                             e.a_out, e.a_oe, e.b_out, e.b_oe);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #400000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: replay of both registers straight after reset yields zero
        step(8'hAA, 8'h55, 0, 0, 0, 1, 1, 0, "R1 stored AB zero");
        step(8'hAA, 8'h55, 0, 0, 0, 0, 0, 1, "R1 stored BA zero");
        // R2: outputs off regardless of data and selects
        step(8'hFF, 8'hFF, 0, 0, 1, 1, 0, 0, "R2 off dir1");
        step(8'h81, 8'h7E, 0, 0, 1, 0, 1, 1, "R2 off dir0 stored");
        // R3, R5: B driven with live A data
        step(8'hA5, 8'h00, 0, 0, 0, 1, 0, 0, "R3 R5 live A5");
        step(8'h3C, 8'hFF, 0, 0, 0, 1, 0, 1, "R5 live 3C");
        // R4, R7: A driven with live B data
        step(8'h00, 8'h5A, 0, 0, 0, 0, 0, 0, "R4 R7 live 5A");
        step(8'hFF, 8'hC3, 0, 0, 0, 0, 1, 0, "R7 live C3");
        // R8, R10: capture A while outputs are off, then hold strobe low
        step(8'h11, 8'h00, 1, 0, 1, 0, 0, 0, "R10 strobe rise off");
        step(8'hC3, 8'h00, 0, 0, 1, 0, 0, 0, "R8 fall capture off");
        step(8'h00, 8'h00, 0, 0, 1, 0, 0, 0, "R10 held low");
        // R6: replay stored A data while live A differs
        step(8'hFF, 8'h00, 0, 0, 0, 1, 1, 0, "R6 R8 replay C3");
        // R9, R11: capture B, replay it, confirm A-side register untouched
        step(8'h00, 8'h22, 0, 1, 1, 0, 0, 0, "R9 strobe rise");
        step(8'h00, 8'h96, 0, 0, 1, 0, 0, 0, "R9 fall capture");
        step(8'h00, 8'h01, 0, 0, 0, 0, 0, 1, "R9 replay 96");
        step(8'h0F, 8'h01, 0, 0, 0, 1, 1, 0, "R11 AB kept C3");
        // R10: strobe held high while data changes loads nothing
        step(8'h77, 8'h00, 1, 0, 0, 1, 1, 0, "R10 rise A");
        step(8'h66, 8'h00, 1, 0, 0, 1, 1, 0, "R10 held high");
        step(8'h55, 8'h00, 1, 0, 0, 1, 1, 0, "R10 held high 2");
        step(8'h44, 8'h00, 0, 0, 0, 1, 1, 0, "R8 fall takes 44");
        // R11: both directions captured together stay distinct
        step(8'h00, 8'h00, 1, 1, 1, 0, 0, 0, "R11 both rise");
        step(8'hE7, 8'h18, 0, 0, 1, 0, 0, 0, "R11 both fall");
        step(8'h00, 8'h00, 0, 0, 0, 1, 1, 1, "R11 replay AB E7");
        step(8'h00, 8'h00, 0, 0, 0, 0, 1, 1, "R11 R12 replay BA 18");
        // R2 again after stored data exists
        step(8'h12, 8'h34, 0, 0, 1, 1, 1, 1, "R2 off with data");
        repeat (3) @(posedge clk);
        #2;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule